// File: doc/BRIEF.md
# Converter Frame Packer for a Serial Data-Converter Link

This block sits between a single converter's sample path and the link layer of a JESD204B-style transmitter. On every frame clock it accepts a group of four samples, each with up to two control bits. It shapes every sample into a 12- or 16-bit word made of data bits, then control bits, then zero tail bits. It joins the four words into one frame and cuts the frame into octets, which it deals out across a configurable number of lanes. Each active lane receives one word of F octets per frame clock, together with a valid strobe.

The lane count, octets per lane, word size, data resolution, control-bit count and the lane-straddling switch are quasi-static inputs. A configuration that cannot carry exactly one frame is reported on an error flag, and no lane is marked valid while the error is present. Scrambling, line coding, alignment characters and serialization are handled by later stages.

Top module: `jtp_frame_packer`

## Requirements
- R1: While reset is asserted, every lane output word is zero, every lane valid strobe is low and the error flag is low.
- R2: All outputs are registered. Inputs sampled at one rising clock edge appear at the outputs just after that same edge, so the latency is one frame clock.
- R3: Each sample word holds `cfg_res` data bits, then `cfg_ctrl_bits` control bits, then zero tail bits up to the word size. The data bits are the top `cfg_res` bits of the input sample. With two control bits, control bit 1 comes before control bit 0. With one control bit, only control bit 0 is sent.
- R4: `cfg_word16` = 1 selects 16-bit words and 0 selects 12-bit words. The frame is the concatenation of the four words, most significant bit first, with sample 0 first. Sample i is taken from `in_samples[16*i+15:16*i]` and its control bits from `in_ctrl[2*i+1:2*i]`.
- R5: Lane j carries frame octets j·F to j·F+F−1. It is output on `lane_data[64*j+63:64*j]` with its first octet in bits 63:56. Octet positions beyond F are zero.
- R6: When `in_valid` is high and the configuration is legal, the valid strobes of lanes 0 to L−1 go high and all other strobes stay low. When `in_valid` is low, every strobe is low.
- R7: A configuration is legal only if L is between 1 and 8, F is 1, 2, 4 or 8, and F·L·8 equals four times the word size. Any other configuration raises `config_error` and holds every valid strobe low.
- R8: When `cfg_hd` = 0, the bits per lane (8·F) must be a whole multiple of the word size, so that no sample spans two lanes. Otherwise `config_error` is raised. When `cfg_hd` = 1, samples may span lanes.
- R9: `config_error` is also raised when `cfg_res` is 0, when `cfg_ctrl_bits` exceeds 2, or when `cfg_res` plus `cfg_ctrl_bits` exceeds the word size.
- R10: The output word of any lane whose valid strobe is low is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The four input samples are valid this frame clock |
| in_samples | input | 64 | Four 16-bit samples, sample 0 in the low bits |
| in_ctrl | input | 8 | Two control bits per sample, sample 0 in the low bits |
| cfg_lanes | input | 4 | Active lane count L |
| cfg_octets | input | 4 | Octets per lane per frame F |
| cfg_word16 | input | 1 | 1: 16-bit words, 0: 12-bit words |
| cfg_ctrl_bits | input | 2 | Control bits per sample (0 to 2) |
| cfg_res | input | 5 | Data bits kept per sample |
| cfg_hd | input | 1 | 1: samples may span two lanes |
| lane_data | output | 512 | Eight 64-bit lane words, lane 0 in the low bits |
| lane_valid | output | 8 | Per-lane valid strobe |
| config_error | output | 1 | Current configuration cannot carry a frame |

## Verification
The packer is driven with all-ones, alternating-bit and random samples under single-lane, two-, four- and eight-lane 16-bit layouts and three- and six-lane 12-bit layouts. Together these separate mistakes in sample order, bit order within a word, octet-to-lane dealing and the masking of unused octets. Tail lengths of zero, one, two and six bits, each combined with random control bits, expose misplaced control fields and tail bits that are not cleared. Illegal settings are applied one rule at a time (size mismatch, odd F, zero lanes, straddling without permission, over-long fields) to show that each rule alone raises the flag. Back-to-back frames with the layout switching on every cycle pin down the single-cycle latency.

// File: rtl/jtp_pkg.sv
package jtp_pkg;
    // fixed protocol facts of the frame layout
    localparam int SPF         = 4;   // samples per frame
    localparam int OCTET_W     = 8;
    localparam int WORD_NARROW = 12;  // narrow word size
    localparam int CTRL_W      = 2;   // control bits carried per sample input
    localparam int CTRL_MAX    = 2;
    localparam int CS_W        = 2;   // width of the control-count field
endpackage

// File: rtl/jtp_cfg_check.sv
module jtp_cfg_check
    import jtp_pkg::*;
#(
    parameter int MAX_LANES  = 8,
    parameter int MAX_OCTETS = 8,
    parameter int SAMPLE_W   = 16,
    parameter int LC_W       = 4,
    parameter int OC_W       = 4,
    parameter int RES_W      = 5
) (
    input  logic [LC_W-1:0]  cfg_lanes,
    input  logic [OC_W-1:0]  cfg_octets,
    input  logic             cfg_word16,
    input  logic [CS_W-1:0]  cfg_ctrl_bits,
    input  logic [RES_W-1:0] cfg_res,
    input  logic             cfg_hd,
    output logic             cfg_err
);
    int l_v, f_v, np_v, r_v, c_v;
    logic ok;

    always_comb begin
        l_v  = int'(cfg_lanes);
        f_v  = int'(cfg_octets);
        r_v  = int'(cfg_res);
        c_v  = int'(cfg_ctrl_bits);
        np_v = cfg_word16 ? SAMPLE_W : WORD_NARROW;
        ok   = 1'b1;
        // lane count range
        if (l_v < 1 || l_v > MAX_LANES) ok = 1'b0;
        // octets per lane: power of two within range
        if (f_v < 1 || f_v > MAX_OCTETS || (f_v & (f_v - 1)) != 0) ok = 1'b0;
        // lanes times octets must carry exactly one frame
        if (f_v * l_v * OCTET_W != SPF * np_v) ok = 1'b0;
        // without straddling, each lane holds whole words
        if (!cfg_hd && ((f_v * OCTET_W) % np_v) != 0) ok = 1'b0;
        // field widths must fit inside the word
        if (r_v < 1 || c_v > CTRL_MAX || r_v + c_v > np_v) ok = 1'b0;
        cfg_err = !ok;
    end
endmodule

// File: rtl/jtp_sample_fmt.sv
module jtp_sample_fmt
    import jtp_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int RES_W    = 5
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [CTRL_W-1:0]   ctrl,
    input  logic [RES_W-1:0]    res,
    input  logic [CS_W-1:0]     cs,
    output logic [SAMPLE_W-1:0] word
);
    logic [SAMPLE_W-1:0] keep_mask;
    logic [CTRL_W:0]     ctrl_mask_ext;
    logic [CTRL_W-1:0]   ctrl_m;
    logic [SAMPLE_W-1:0] ctrl_placed;
    int                  gap;

    always_comb begin
        // data field: top res bits of the sample, left-aligned
        keep_mask     = ~({SAMPLE_W{1'b1}} >> res);
        // low cs control bits are sent, higher one first
        ctrl_mask_ext = ({{CTRL_W{1'b0}}, 1'b1} << cs) - (CTRL_W + 1)'(1);
        ctrl_m        = ctrl & ctrl_mask_ext[CTRL_W-1:0];
        gap           = SAMPLE_W - int'(res) - int'(cs);
        if (gap >= 0) ctrl_placed = SAMPLE_W'(ctrl_m) << gap;
        else          ctrl_placed = '0;
        // remaining tail positions stay zero
        word = (sample & keep_mask) | ctrl_placed;
    end
endmodule

// File: rtl/jtp_lane_map.sv
module jtp_lane_map
    import jtp_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int MAX_LANES  = 8,
    parameter int MAX_OCTETS = 8,
    parameter int OC_W       = 4
) (
    input  logic [SPF-1:0][SAMPLE_W-1:0]         words,
    input  logic                                 word16,
    input  logic [OC_W-1:0]                      octets,
    output logic [MAX_LANES-1:0][MAX_OCTETS*OCTET_W-1:0] lanes
);
    localparam int FRAME_W = SPF * SAMPLE_W;
    localparam int LANE_W  = MAX_OCTETS * OCTET_W;
    localparam int BIG_W   = FRAME_W + LANE_W;

    logic [FRAME_W-1:0] frame;

    // frame assembly: sample 0 occupies the most significant bits
    always_comb begin
        frame = '0;
        for (int i = 0; i < SPF; i++) begin
            if (word16)
                frame = frame | (FRAME_W'(words[i]) << (FRAME_W - (i + 1) * SAMPLE_W));
            else
                frame = frame | (FRAME_W'(words[i][SAMPLE_W-1 -: WORD_NARROW])
                                 << (FRAME_W - (i + 1) * WORD_NARROW));
        end
    end

    for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
        logic [BIG_W-1:0]  shifted;
        logic [LANE_W-1:0] lane_v;
        int                seg;
        always_comb begin
            seg     = int'(octets) * OCTET_W;
            shifted = {frame, {LANE_W{1'b0}}} << (j * seg);
            lane_v  = shifted[BIG_W-1 -: LANE_W] & ~({LANE_W{1'b1}} >> seg);
        end
        assign lanes[j] = lane_v;
    end
endmodule

// File: rtl/jtp_frame_packer.sv
module jtp_frame_packer
    import jtp_pkg::*;
#(
    parameter int MAX_LANES  = 8,
    parameter int MAX_OCTETS = 8,
    parameter int SAMPLE_W   = 16,
    localparam int LANE_W    = MAX_OCTETS * OCTET_W,
    localparam int LC_W      = $clog2(MAX_LANES + 1),
    localparam int OC_W      = $clog2(MAX_OCTETS + 1),
    localparam int RES_W     = $clog2(SAMPLE_W + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [SPF*SAMPLE_W-1:0]      in_samples,
    input  logic [SPF*CTRL_W-1:0]        in_ctrl,
    input  logic [LC_W-1:0]              cfg_lanes,
    input  logic [OC_W-1:0]              cfg_octets,
    input  logic                         cfg_word16,
    input  logic [CS_W-1:0]              cfg_ctrl_bits,
    input  logic [RES_W-1:0]             cfg_res,
    input  logic                         cfg_hd,
    output logic [MAX_LANES*LANE_W-1:0]  lane_data,
    output logic [MAX_LANES-1:0]         lane_valid,
    output logic                         config_error
);
    typedef struct packed {
        logic [MAX_LANES-1:0][LANE_W-1:0] data;
        logic [MAX_LANES-1:0]             valid;
        logic                             err;
    } out_t;

    out_t st_d, st_q;

    logic [SPF-1:0][SAMPLE_W-1:0]      words;
    logic [MAX_LANES-1:0][LANE_W-1:0]  lanes;
    logic                              cfg_err;

    for (genvar i = 0; i < SPF; i++) begin : g_fmt
        jtp_sample_fmt #(
            .SAMPLE_W (SAMPLE_W),
            .RES_W    (RES_W)
        ) i_fmt (
            .sample (in_samples[i*SAMPLE_W +: SAMPLE_W]),
            .ctrl   (in_ctrl[i*CTRL_W +: CTRL_W]),
            .res    (cfg_res),
            .cs     (cfg_ctrl_bits),
            .word   (words[i])
        );
    end

    jtp_cfg_check #(
        .MAX_LANES  (MAX_LANES),
        .MAX_OCTETS (MAX_OCTETS),
        .SAMPLE_W   (SAMPLE_W),
        .LC_W       (LC_W),
        .OC_W       (OC_W),
        .RES_W      (RES_W)
    ) i_cfg (
        .cfg_lanes     (cfg_lanes),
        .cfg_octets    (cfg_octets),
        .cfg_word16    (cfg_word16),
        .cfg_ctrl_bits (cfg_ctrl_bits),
        .cfg_res       (cfg_res),
        .cfg_hd        (cfg_hd),
        .cfg_err       (cfg_err)
    );

    jtp_lane_map #(
        .SAMPLE_W   (SAMPLE_W),
        .MAX_LANES  (MAX_LANES),
        .MAX_OCTETS (MAX_OCTETS),
        .OC_W       (OC_W)
    ) i_map (
        .words  (words),
        .word16 (cfg_word16),
        .octets (cfg_octets),
        .lanes  (lanes)
    );

    always_comb begin
        st_d     = '0;
        st_d.err = cfg_err;
        for (int j = 0; j < MAX_LANES; j++) begin
            if (in_valid && !cfg_err && j < int'(cfg_lanes)) begin
                st_d.valid[j] = 1'b1;
                st_d.data[j]  = lanes[j];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lane_data    = st_q.data;
    assign lane_valid   = st_q.valid;
    assign config_error = st_q.err;

    // R7: a flagged configuration never releases a lane
    p_err_blocks_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> st_q.valid == '0);

    // R2: a strobe only follows an accepted input one edge earlier
    p_valid_follows_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|st_q.valid) |-> $past(in_valid));

    // R6: the number of strobes equals the lane count of the frame it carries
    p_lane_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|st_q.valid) |-> $countones(st_q.valid) == int'($past(cfg_lanes)));

    for (genvar j = 1; j < MAX_LANES; j++) begin : g_contig
        // R6: active lanes form a contiguous group from lane 0
        p_lanes_contiguous_r6: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.valid[j] |-> st_q.valid[j-1]);
    end

    for (genvar j = 0; j < MAX_LANES; j++) begin : g_idle
        // R10: a lane without a strobe shows a zero word
        p_idle_lane_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !st_q.valid[j] |-> st_q.data[j] == '0);
    end
endmodule

// File: tb/test_jtp_frame_packer.sv
`timescale 1ns/1ps
module test_jtp_frame_packer;
    localparam int NL = 8;
    localparam int LW = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [63:0]  in_samples = '0;
    logic [7:0]   in_ctrl = '0;
    logic [3:0]   cfg_lanes = 4'd1;
    logic [3:0]   cfg_octets = 4'd8;
    logic         cfg_word16 = 1'b1;
    logic [1:0]   cfg_ctrl_bits = 2'd0;
    logic [4:0]   cfg_res = 5'd16;
    logic         cfg_hd = 1'b0;
    logic [511:0] lane_data;
    logic [7:0]   lane_valid;
    logic         config_error;

    always #10 clk = ~clk;

    jtp_frame_packer i_jtp_frame_packer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
        .in_ctrl(in_ctrl), .cfg_lanes(cfg_lanes), .cfg_octets(cfg_octets),
        .cfg_word16(cfg_word16), .cfg_ctrl_bits(cfg_ctrl_bits), .cfg_res(cfg_res),
        .cfg_hd(cfg_hd), .lane_data(lane_data), .lane_valid(lane_valid),
        .config_error(config_error)
    );

    typedef struct {
        logic [511:0] d;
        logic [7:0]   v;
        logic         e;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   finished = 0;

    // staged configuration, applied by the driver at the next falling edge
    int n_l = 1, n_f = 8, n_cs = 0, n_res = 16;
    bit n_w16 = 1, n_hd = 0;

    function automatic void model(input bit vld, input logic [63:0] smp, input logic [7:0] ctl,
                                  input int l, input int f, input bit w16, input int cs,
                                  input int res, input bit hd,
                                  output logic [511:0] d, output logic [7:0] v, output logic e);
        int np;
        bit ok;
        bit fb[64];
        int idx;
        np = w16 ? 16 : 12;
        ok = (l >= 1 && l <= 8) && (f == 1 || f == 2 || f == 4 || f == 8) &&
             (f * l * 8 == 4 * np) && (hd || ((f * 8) % np) == 0) &&
             (res >= 1) && (cs <= 2) && (res + cs <= np);
        e = !ok;
        d = '0;
        v = '0;
        idx = 0;
        for (int k = 0; k < 64; k++) fb[k] = 1'b0;
        for (int s = 0; s < 4; s++) begin
            for (int b = 0; b < np; b++) begin
                if (b < res)           fb[idx] = smp[s*16 + 15 - b];
                else if (b < res + cs) fb[idx] = ctl[s*2 + (cs - 1 - (b - res))];
                else                   fb[idx] = 1'b0;
                idx++;
            end
        end
        if (vld && ok) begin
            for (int j = 0; j < l; j++) begin
                v[j] = 1'b1;
                for (int k = 0; k < f; k++)
                    for (int m = 0; m < 8; m++)
                        d[j*LW + 63 - k*8 - m] = fb[(j*f + k)*8 + m];
            end
        end
    endfunction

    task automatic send(input bit vld, input logic [63:0] s, input logic [7:0] c, input string tag);
        exp_t x;
        @(negedge clk);
        in_valid      = vld;
        in_samples    = s;
        in_ctrl       = c;
        cfg_lanes     = 4'(n_l);
        cfg_octets    = 4'(n_f);
        cfg_word16    = n_w16;
        cfg_ctrl_bits = 2'(n_cs);
        cfg_res       = 5'(n_res);
        cfg_hd        = n_hd;
        model(vld, s, c, n_l, n_f, n_w16, n_cs, n_res, n_hd, x.d, x.v, x.e);
        x.tag = tag;
        exp_q.push_back(x);
    endtask

    task automatic set_cfg(input int l, input int f, input bit w16, input int cs,
                           input int res, input bit hd);
        n_l = l; n_f = f; n_w16 = w16; n_cs = cs; n_res = res; n_hd = hd;
    endtask

    task automatic burst(input string tag);
        send(1, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, tag);
        send(1, 64'hA5C3_5A3C_0FF0_9669, 8'h9C, tag);
        send(1, {$urandom, $urandom}, 8'($urandom), tag);
        send(1, {$urandom, $urandom}, 8'($urandom), tag);
    endtask

    // monitor: compares one queued item just after each rising edge
    initial begin
        exp_t x;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                x = exp_q.pop_front();
                checks++;
                if (lane_data !== x.d) begin
                    fails++;
                    $display("FAIL %s lane_data actual %h expected %h", x.tag, lane_data, x.d);
                end
                checks++;
                if (lane_valid !== x.v) begin
                    fails++;
                    $display("FAIL %s lane_valid actual %h expected %h", x.tag, lane_valid, x.v);
                end
                checks++;
                if (config_error !== x.e) begin
                    fails++;
                    $display("FAIL %s config_error actual %b expected %b", x.tag, config_error, x.e);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        in_samples = 64'hDEAD_BEEF_1234_5678;
        in_valid   = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state while inputs are active
        checks++;
        if (lane_data !== '0) begin
            fails++;
            $display("FAIL R1 lane_data actual %h expected 0", lane_data);
        end
        checks++;
        if (lane_valid !== '0) begin
            fails++;
            $display("FAIL R1 lane_valid actual %h expected 0", lane_valid);
        end
        checks++;
        if (config_error !== 1'b0) begin
            fails++;
            $display("FAIL R1 config_error actual %b expected 0", config_error);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;

        set_cfg(1, 8, 1, 0, 16, 0); burst("R3 R4 R5 w16 L1 F8");
        set_cfg(2, 4, 1, 2, 12, 0); burst("R3 R5 w16 L2 F4 cs2 tail2");
        set_cfg(4, 2, 1, 1, 14, 0); burst("R3 R5 w16 L4 F2 cs1 tail1");
        set_cfg(8, 1, 1, 0, 10, 1); burst("R5 R8 w16 L8 F1 straddle tail6");
        set_cfg(6, 1, 0, 2, 10, 1); burst("R4 R5 w12 L6 F1 cs2");
        set_cfg(3, 2, 0, 1, 11, 1); burst("R4 R5 w12 L3 F2 cs1");

        set_cfg(2, 4, 1, 0, 16, 0);
        send(0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, "R6 R10 idle input");
        send(0, 64'h1234_5678_9ABC_DEF0, 8'h55, "R6 R10 idle input");

        set_cfg(8, 1, 1, 0, 16, 0); burst("R8 w16 straddle not allowed");
        set_cfg(6, 1, 0, 0, 12, 0); burst("R8 w12 straddle not allowed");
        set_cfg(4, 4, 1, 0, 16, 0); burst("R7 size mismatch");
        set_cfg(2, 3, 0, 0, 12, 1); burst("R7 F not power of two");
        set_cfg(0, 8, 1, 0, 16, 0); burst("R7 zero lanes");
        set_cfg(1, 8, 1, 2, 15, 0); burst("R9 fields overflow word");
        set_cfg(1, 8, 1, 0, 0, 0);  burst("R9 zero resolution");
        set_cfg(1, 8, 1, 3, 8, 0);  burst("R9 three control bits");

        // R2: layout changes on every cycle, each frame seen one edge later
        for (int r = 0; r < 6; r++) begin
            set_cfg(1, 8, 1, 0, 16, 0);
            send(1, {$urandom, $urandom}, 8'($urandom), "R2 back-to-back w16");
            set_cfg(6, 1, 0, 2, 9, 1);
            send(1, {$urandom, $urandom}, 8'($urandom), "R2 back-to-back w12");
            set_cfg(4, 4, 1, 0, 16, 0);
            send(1, {$urandom, $urandom}, 8'($urandom), "R2 R7 back-to-back error");
        end
        set_cfg(4, 2, 1, 2, 13, 0); burst("R6 R7 recovery after error");

        repeat (4) @(posedge clk);
        #2;
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule